// File: doc/BRIEF.md
# Four-Channel Serial DAC Update Sequencer

This block refreshes all four outputs of a quad 12-bit serial DAC from a single sample request. The request line may come from any clock domain. It passes through a synchronizer first. On each rising edge of the synchronized request, the block takes a snapshot of the four channel values. It then writes them to the converter as four 32-bit serial frames over chip select, serial clock and data-out lines, starting with channel 0. The converter's clear line is kept inactive throughout.

Inside, a sequencer builds each frame from a fixed write-and-update command, the channel address and the captured data word. It hands the frame to a serial shift engine through a one-cycle start request. It waits for the engine's finish flag before the next frame may begin. A request that arrives while a sequence is running is remembered and runs as soon as the current sequence ends. A one-cycle done pulse marks the end of each four-frame sequence.

Top module: `qdac_update_seq`

## Requirements
- R1: Each frame is 32 bits sent MSB first, laid out from the top bit down as follows: bits 31..24 are zero, bits 23..20 hold the command 4'b0011, bits 19..16 hold the channel address, bits 15..4 hold the 12-bit value, and bits 3..0 are zero.
- R2: One request produces exactly four frames with addresses 0, 1, 2 and 3, in that order. Channel k takes its value from `ch_data[12k+11:12k]`.
- R3: A rising edge on `req_async` starts a sequence through a two-stage synchronizer. Chip select falls at the fourth rising clock edge after the request rises. All four values are captured when the request is accepted, so changes to `ch_data` after that point do not reach the frames.
- R4: The data line changes only while the serial clock is low and is set up one clock before each serial clock rise. The serial clock is high for exactly one system clock per bit.
- R5: Chip select is low for the whole of a frame, with exactly 32 serial clock pulses in each low period. The serial clock never rises while chip select is high.
- R6: A new frame begins only after the shift engine is idle again. Inside a sequence, chip select stays high for exactly 3 clocks between frames.
- R7: `dac_clr_n` is high at all times, including during reset.
- R8: A request that arrives during a sequence is held and serviced right after the fourth frame, using the values present at that moment. Several requests during one sequence merge into a single extra sequence.
- R9: `seq_done` pulses high for exactly one clock, two clocks after chip select rises at the end of the fourth frame, and never during a frame.
- R10: Reset gives chip select high, serial clock low, `seq_done` low and no pending request. A sequence cut short by reset does not resume.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_async | input | 1 | Sample request; its rising edge is used and it may be asynchronous |
| ch_data | input | 48 | Four 12-bit channel values, channel k at bits [12k+11:12k] |
| dac_cs_n | output | 1 | Converter chip select, active low |
| dac_sck | output | 1 | Serial clock |
| dac_mosi | output | 1 | Serial data to the converter |
| dac_clr_n | output | 1 | Converter clear, held inactive high |
| seq_done | output | 1 | One-cycle pulse after the fourth frame |

## Verification
Each result has a fixed cycle position. Chip select falls four rising edges after the request. Each bit takes three clocks, with the serial clock high in the middle one. Chip select stays high for three clocks between frames of one sequence. The done pulse comes two clocks after the last chip-select rise. The bench drives and samples on the falling clock edge and counts those edges, so each of these distances is compared exactly rather than waited on loosely. Frames are rebuilt by shifting the data line at every serial clock rise, and each finished frame is compared against the expected command, address and value.

// File: rtl/qdac_pkg.sv
`timescale 1ns/1ps
package qdac_pkg;

   typedef enum logic [2:0] {
      SH_IDLE,
      SH_SETUP,
      SH_HIGH,
      SH_LOW,
      SH_TAIL
   } shift_state_t;

   typedef enum logic [1:0] {
      SQ_IDLE,
      SQ_SEND,
      SQ_WAIT
   } seq_state_t;

   localparam logic [3:0] CMD_WRITE_UPDATE = 4'b0011;

endpackage

// File: rtl/qdac_req_sync.sv
`timescale 1ns/1ps
module qdac_req_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic req_async,
   output logic req_rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("qdac_req_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;
   logic              last_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         chain  <= '0;
         last_q <= 1'b0;
      end else begin
         chain  <= {chain[STAGES-2:0], req_async};
         last_q <= chain[STAGES-1];
      end
   end

   assign req_rise = chain[STAGES-1] & ~last_q;

endmodule

// File: rtl/qdac_shifter.sv
`timescale 1ns/1ps
module qdac_shifter
   import qdac_pkg::*;
#(
   parameter int FRAME_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic [FRAME_W-1:0] frame,
   output logic               cs_n,
   output logic               sck,
   output logic               mosi,
   output logic               finish
);

   localparam int CNT_W = $clog2(FRAME_W);

   if (FRAME_W < 2) begin : g_bad_frame
      $error("qdac_shifter: FRAME_W must be at least 2");
   end

   shift_state_t       state;
   logic [FRAME_W-1:0] shreg;
   logic [CNT_W-1:0]   bit_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SH_IDLE;
         shreg   <= '0;
         bit_cnt <= '0;
      end else begin
         case (state)
            SH_IDLE: begin
               if (start) begin
                  shreg   <= frame;
                  bit_cnt <= '0;
                  state   <= SH_SETUP;
               end
            end
            SH_SETUP: state <= SH_HIGH;
            SH_HIGH:  state <= SH_LOW;
            SH_LOW: begin
               shreg <= {shreg[FRAME_W-2:0], 1'b0};
               if (bit_cnt == CNT_W'(FRAME_W - 1)) begin
                  state <= SH_TAIL;
               end else begin
                  bit_cnt <= bit_cnt + 1'b1;
                  state   <= SH_SETUP;
               end
            end
            SH_TAIL:  state <= SH_IDLE;
            default:  state <= SH_IDLE;
         endcase
      end
   end

   always_comb begin
      cs_n   = (state == SH_IDLE) || (state == SH_TAIL);
      sck    = (state == SH_HIGH);
      mosi   = cs_n ? 1'b0 : shreg[FRAME_W-1];
      finish = (state == SH_IDLE);
   end

endmodule

// File: rtl/qdac_sequencer.sv
`timescale 1ns/1ps
module qdac_sequencer
   import qdac_pkg::*;
#(
   parameter int          CHANNELS = 4,
   parameter int          DATA_W   = 12,
   parameter int          ADDR_W   = 4,
   parameter int          CMD_W    = 4,
   parameter int          PAD_LO   = 4,
   parameter int          FRAME_W  = 32,
   parameter logic [CMD_W-1:0] CMD = CMD_WRITE_UPDATE
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_rise,
   input  logic [CHANNELS*DATA_W-1:0] ch_data,
   input  logic                       ser_finish,
   output logic                       ser_start,
   output logic [FRAME_W-1:0]         frame,
   output logic                       done
);

   localparam int PAD_HI = FRAME_W - CMD_W - ADDR_W - DATA_W - PAD_LO;
   localparam int IDX_W  = $clog2(CHANNELS);

   if (PAD_HI < 1 || PAD_LO < 1) begin : g_bad_layout
      $error("qdac_sequencer: frame fields do not fit FRAME_W");
   end
   if (CHANNELS < 2 || CHANNELS > (1 << ADDR_W)) begin : g_bad_channels
      $error("qdac_sequencer: CHANNELS out of range for ADDR_W");
   end

   seq_state_t        state;
   logic [IDX_W-1:0]  idx;
   logic              pending;
   logic              capture;
   logic [DATA_W-1:0] held [CHANNELS];

   assign capture = (state == SQ_IDLE) && (req_rise || pending);

   for (genvar k = 0; k < CHANNELS; k++) begin : g_hold
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       held[k] <= '0;
         else if (capture) held[k] <= ch_data[k*DATA_W +: DATA_W];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= SQ_IDLE;
         idx     <= '0;
         pending <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (capture)       pending <= 1'b0;
         else if (req_rise) pending <= 1'b1;
         case (state)
            SQ_IDLE: begin
               if (capture) begin
                  idx   <= '0;
                  state <= SQ_SEND;
               end
            end
            SQ_SEND: begin
               if (ser_finish) state <= SQ_WAIT;
            end
            SQ_WAIT: begin
               if (ser_finish) begin
                  if (idx == IDX_W'(CHANNELS - 1)) begin
                     done  <= 1'b1;
                     state <= SQ_IDLE;
                  end else begin
                     idx   <= idx + 1'b1;
                     state <= SQ_SEND;
                  end
               end
            end
            default: state <= SQ_IDLE;
         endcase
      end
   end

   assign ser_start = (state == SQ_SEND) && ser_finish;
   assign frame     = {{PAD_HI{1'b0}}, CMD, ADDR_W'(idx), held[idx], {PAD_LO{1'b0}}};

endmodule

// File: rtl/qdac_update_seq.sv
`timescale 1ns/1ps
module qdac_update_seq
   import qdac_pkg::*;
#(
   parameter int CHANNELS    = 4,
   parameter int DATA_W      = 12,
   parameter int ADDR_W      = 4,
   parameter int CMD_W       = 4,
   parameter int PAD_LO      = 4,
   parameter int FRAME_W     = 32,
   parameter int SYNC_STAGES = 2
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       req_async,
   input  logic [CHANNELS*DATA_W-1:0] ch_data,
   output logic                       dac_cs_n,
   output logic                       dac_sck,
   output logic                       dac_mosi,
   output logic                       dac_clr_n,
   output logic                       seq_done
);

   logic               req_rise;
   logic               ser_start;
   logic               ser_finish;
   logic [FRAME_W-1:0] frame;

   qdac_req_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_async (req_async),
      .req_rise  (req_rise)
   );

   qdac_sequencer #(
      .CHANNELS (CHANNELS),
      .DATA_W   (DATA_W),
      .ADDR_W   (ADDR_W),
      .CMD_W    (CMD_W),
      .PAD_LO   (PAD_LO),
      .FRAME_W  (FRAME_W),
      .CMD      (CMD_W'(CMD_WRITE_UPDATE))
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .req_rise   (req_rise),
      .ch_data    (ch_data),
      .ser_finish (ser_finish),
      .ser_start  (ser_start),
      .frame      (frame),
      .done       (seq_done)
   );

   qdac_shifter #(.FRAME_W(FRAME_W)) u_shift (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (ser_start),
      .frame  (frame),
      .cs_n   (dac_cs_n),
      .sck    (dac_sck),
      .mosi   (dac_mosi),
      .finish (ser_finish)
   );

   assign dac_clr_n = 1'b1;

endmodule

// File: rtl/qdac_update_seq_chk.sv
`timescale 1ns/1ps
module qdac_update_seq_chk #(
   parameter int FRAME_W = 32
) (
   input logic clk,
   input logic rst_n,
   input logic cs_n,
   input logic sck,
   input logic mosi,
   input logic done
);

   localparam int PC_W = $clog2(FRAME_W + 1);

   logic [PC_W-1:0] pulse_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   pulse_cnt <= '0;
      else if (cs_n) pulse_cnt <= '0;
      else if (sck)  pulse_cnt <= pulse_cnt + 1'b1;
   end

   p_sck_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sck |-> !cs_n);

   p_pulse_count_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |-> (pulse_cnt == PC_W'(FRAME_W)));

   p_sck_width_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sck |=> !sck);

   p_mosi_setup_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sck) |-> $stable(mosi));

   p_mosi_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      sck |=> $stable(mosi));

   p_frame_gap_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cs_n) |=> cs_n);

   p_done_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> cs_n);

endmodule

bind qdac_update_seq qdac_update_seq_chk #(.FRAME_W(FRAME_W)) u_chk (
   .clk   (clk),
   .rst_n (rst_n),
   .cs_n  (dac_cs_n),
   .sck   (dac_sck),
   .mosi  (dac_mosi),
   .done  (seq_done)
);

// File: tb/qdac_update_seq_bench.sv
`timescale 1ns/1ps
module qdac_update_seq_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_async = 1'b0;
   logic [47:0] ch_data = '0;
   logic        dac_cs_n, dac_sck, dac_mosi, dac_clr_n, seq_done;

   always #10 clk = ~clk;

   qdac_update_seq u_qdac_update_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_async (req_async),
      .ch_data   (ch_data),
      .dac_cs_n  (dac_cs_n),
      .dac_sck   (dac_sck),
      .dac_mosi  (dac_mosi),
      .dac_clr_n (dac_clr_n),
      .seq_done  (seq_done)
   );

   localparam logic [47:0] VECS [5] = '{
      48'hFFF_800_001_000,
      48'h123_456_789_ABC,
      48'hA5A_5A5_0F0_F0F,
      48'h000_FFF_000_FFF,
      48'h4D9_2B6_7E1_135
   };

   int checks = 0;
   int fails  = 0;

   task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_frame(input int ch, input logic [11:0] d);
      return {8'h00, 4'b0011, 4'(ch), d, 4'h0};
   endfunction

   // monitor: decodes frames at falling clock edges
   logic [31:0] frames [64];
   int          fbits  [64];
   int          fgap   [64];
   int          fcount = 0;
   int          bits = 0;
   int          hi_cnt = 0;
   int          since_rise = 0;
   int          done_cnt = 0;
   logic [31:0] sh = '0;
   logic        prev_sck = 1'b0, prev_cs = 1'b1, prev_done = 1'b0;

   always @(negedge clk) begin
      if (!rst_n) begin
         bits = 0; hi_cnt = 0;
         prev_sck = 1'b0; prev_cs = 1'b1; prev_done = 1'b0;
      end else begin
         if (dac_sck && !prev_sck) begin
            sh = {sh[30:0], dac_mosi};
            bits++;
         end
         if (!dac_cs_n && prev_cs && fcount < 64) fgap[fcount] = hi_cnt;
         if (dac_cs_n && !prev_cs && fcount < 64) begin
            frames[fcount] = sh;
            fbits[fcount]  = bits;
            fcount++;
            bits = 0;
            since_rise = 0;
         end else begin
            since_rise++;
         end
         if (dac_cs_n) hi_cnt++; else hi_cnt = 0;
         if (seq_done) begin
            done_cnt++;
            // R9: done two clocks after last chip-select rise, after a whole sequence
            chk(since_rise == 2 && (fcount % 4) == 0, "R9 done position", since_rise, 2);
            chk(!prev_done, "R9 done width", prev_done, 0);
            chk(dac_cs_n, "R9 done outside frame", dac_cs_n, 1);
         end
         chk(dac_clr_n === 1'b1, "R7 clear held high", dac_clr_n, 1);
         prev_sck = dac_sck; prev_cs = dac_cs_n; prev_done = seq_done;
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
      #1;
   endtask

   task automatic wait_done(input int target);
      int n = 0;
      while (done_cnt < target && n < 3000) begin
         @(negedge clk); #1; n++;
      end
      chk(done_cnt >= target, "R9 done timeout", done_cnt, target);
   endtask

   task automatic check_seq(input int base, input logic [47:0] v);
      for (int c = 0; c < 4; c++) begin
         logic [31:0] e;
         e = exp_frame(c, v[c*12 +: 12]);
         chk(frames[base+c] === e, "R1 frame content", frames[base+c], e);
         chk(frames[base+c][19:16] == 4'(c), "R2 address order", 32'(frames[base+c][19:16]), c);
         chk(fbits[base+c] == 32, "R5 pulses per frame", fbits[base+c], 32);
         if (c > 0) chk(fgap[base+c] == 3, "R6 gap between frames", fgap[base+c], 3);
      end
   endtask

   task automatic pulse_req();
      @(negedge clk); #3 req_async = 1'b1;
      tick(3);
      req_async = 1'b0;
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   endtask

   initial begin
      #(20 * 150000);
      chk(1'b0, "watchdog expired", 0, 1);
      finish_run();
   end

   initial begin
      int base;
      int lat;
      int fsave;
      // R10: reset state
      tick(3);
      chk(dac_cs_n === 1'b1, "R10 reset cs high", dac_cs_n, 1);
      chk(dac_sck === 1'b0, "R10 reset sck low", dac_sck, 0);
      chk(seq_done === 1'b0, "R10 reset done low", seq_done, 0);
      chk(dac_clr_n === 1'b1, "R7 clear high in reset", dac_clr_n, 1);
      @(negedge clk); rst_n = 1'b1;
      tick(10);
      chk(fcount == 0, "R10 nothing pending after reset", fcount, 0);

      // table walk: R1 R2 R3 R5 R6
      foreach (VECS[i]) begin
         base = fcount;
         @(negedge clk); ch_data = VECS[i];
         #3 req_async = 1'b1;
         lat = 0;
         do begin @(negedge clk); lat++; end while (dac_cs_n && lat < 20);
         chk(lat == 4, "R3 request to cs latency", lat, 4);
         #1 ch_data = ~VECS[i];   // R3: late change must not reach the frames
         tick(2); req_async = 1'b0;
         wait_done(i + 1);
         tick(2);
         chk(fcount == base + 4, "R2 four frames per request", fcount, base + 4);
         check_seq(base, VECS[i]);
      end

      // R8: requests during a running sequence merge into one extra sequence
      base = fcount;
      @(negedge clk); ch_data = 48'h111_222_333_444;
      pulse_req();
      while (dac_cs_n) tick(1);
      ch_data = 48'hCBA_987_654_321;
      pulse_req();
      tick(20);
      pulse_req();
      wait_done(done_cnt + 2);
      tick(600);
      chk(fcount == base + 8, "R8 merged pending requests", fcount, base + 8);
      chk(done_cnt == 7, "R8 done count", done_cnt, 7);
      check_seq(base, 48'h111_222_333_444);
      check_seq(base + 4, 48'hCBA_987_654_321);

      // R10: reset mid-sequence with a request pending
      ch_data = 48'h0AA_0BB_0CC_0DD;
      pulse_req();
      tick(150);
      pulse_req();
      tick(5);
      @(negedge clk); rst_n = 1'b0;
      #1;
      chk(dac_cs_n === 1'b1, "R10 cs high in reset", dac_cs_n, 1);
      chk(dac_sck === 1'b0, "R10 sck low in reset", dac_sck, 0);
      tick(2);
      @(negedge clk); rst_n = 1'b1;
      fsave = fcount;
      tick(800);
      chk(fcount == fsave, "R10 no resume after reset", fcount, fsave);
      chk(dac_cs_n === 1'b1, "R10 idle after reset", dac_cs_n, 1);

      finish_run();
   end

endmodule